// File: doc/BRIEF.md
# MII Management Host with Built-in PHY Register Model

This block is the management side of an Ethernet MAC. It presents a small memory-mapped register bank to a host processor. The bank holds a PHY/register selector, a command word, a write-data word and a result word. Behind the bank sits a compact behavioural model of a PHY's management registers, so management transactions finish inside the block. No serial clock or data pin is toggled.

Software picks the target PHY register through the selector word. A write to the write-data word sends a PHY write cycle at once. A PHY read cycle starts only when the read bit of the command word goes from 0 to 1, and the fetched 16-bit value lands in the result word. The PHY model keeps a control register whose self-clearing bits never stick. It reports link state taken from an input pin and returns a fixed "receivers OK" pattern for one extended status register. A set of general-purpose registers follows the bank, and each of them takes a per-register access type chosen by parameter.

Top module: `mgmt_phy_host`

## Requirements
- R1: After synchronous reset, the selector, command, write-data and result words read 0 and the PHY control register is 0. General register g reads its reset value given by parameter.
- R2: The selector word (index 0) keeps written bits 12:8 as the PHY address and bits 4:0 as the PHY register number. All other bits read 0. The PHY address has no effect on any transaction.
- R3: A write to the command word (index 1) is always stored and read back in full. It launches a PHY read cycle only when its bit 0 is 1 and the stored bit 0 was 0.
- R4: A read cycle of PHY register 0 returns the PHY control value. A read cycle of PHY register 1 returns a status word whose only possibly-set bit is bit 2 (link up).
- R5: A read cycle of PHY register 10 returns 0x1800. Any other PHY register number returns 0.
- R6: A write to the write-data word (index 2) stores bits 15:0 only, reads back zero-extended, and performs a PHY write cycle to the selected register in the same clock.
- R7: A PHY write cycle to register 0 stores the value with bits 15 and 8 cleared. PHY write cycles to any other register change nothing.
- R8: The PHY link bit is registered from the inverse of `link_down` every clock, including during reset.
- R9: General register g (index 4+g) follows its access type: read-write stores and reads back; write-only stores but reads 0; write-one-to-clear clears the bits written as 1; read-only ignores writes. The default types for g=0..3 are read-write, write-only, write-one-to-clear and read-only. The default reset values are 0, 0, 0x0000FFFF and 0xA5A50001.
- R10: Read data is registered and appears one clock after the address is presented. Indices above the last general register read 0. Writes to the result word (index 3) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_down | input | 1 | Link-down indication from the line side |
| host_addr | input | ADDR_W | Register index |
| host_wr | input | 1 | Write enable for the current cycle |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data for the previous cycle's index |

## Verification
The hardest case to reach is a read cycle that must not start: the command word is rewritten with its read bit still 1 while the underlying PHY value has changed. The result word has to keep the stale value. The stimulus first flips `link_down` after a completed read of register 1. It then rewrites the command with bit 0 set and confirms the result is unchanged. Only after clearing the bit and setting it again does it expect the new link state. A random phase restricts register numbers to the modelled set so that control masking, the fixed pattern and the edge detection all recur under a per-clock reference model.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_WO  = 2'd1,
    ACC_W1C = 2'd2,
    ACC_RO  = 2'd3
  } acc_e;

  // host-side word indices
  localparam int IDX_SEL    = 0;
  localparam int IDX_CMD    = 1;
  localparam int IDX_WDATA  = 2;
  localparam int IDX_RESULT = 3;
  localparam int IDX_GEN0   = 4;

  // selector field placement
  localparam int SEL_PHY_LSB = 8;
  localparam int SEL_REG_LSB = 0;

  // PHY model register numbers and constants
  localparam int PHY_R_CTRL = 0;
  localparam int PHY_R_STAT = 1;
  localparam int PHY_R_RXOK = 10;
  localparam logic [15:0] RXOK_PATTERN = 16'h1800;
  localparam logic [15:0] CTRL_SELFCLR = 16'h8100;
  localparam int LINK_BIT = 2;

endpackage

// File: rtl/mgmt_phy_stub.sv
module mgmt_phy_stub
  import mgmt_pkg::*;
#(
  parameter int PHY_DW = 16,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_down,
  input  logic              wr_stb,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [PHY_DW-1:0] wr_val,
  input  logic [REG_AW-1:0] rd_reg,
  output logic [PHY_DW-1:0] rd_val,
  output logic [PHY_DW-1:0] ctrl_out,
  output logic              link_out
);

  localparam logic [PHY_DW-1:0] KEEP_MASK = ~PHY_DW'(CTRL_SELFCLR);

  logic [PHY_DW-1:0] ctrl_q;
  logic              link_q;
  logic [PHY_DW-1:0] stat_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_stb && wr_reg == REG_AW'(PHY_R_CTRL)) begin
      ctrl_q <= wr_val & KEEP_MASK;
    end
  end

  // link state sampled every clock, reset included
  always_ff @(posedge clk) begin
    link_q <= ~link_down;
  end

  always_comb begin
    stat_word           = '0;
    stat_word[LINK_BIT] = link_q;
  end

  always_comb begin
    if (rd_reg == REG_AW'(PHY_R_CTRL))      rd_val = ctrl_q;
    else if (rd_reg == REG_AW'(PHY_R_STAT)) rd_val = stat_word;
    else if (rd_reg == REG_AW'(PHY_R_RXOK)) rd_val = PHY_DW'(RXOK_PATTERN);
    else                                    rd_val = '0;
  end

  assign ctrl_out = ctrl_q;
  assign link_out = link_q;

endmodule

// File: rtl/mgmt_gen_bank.sv
module mgmt_gen_bank
  import mgmt_pkg::*;
#(
  parameter int                    N_GEN   = 4,
  parameter int                    DATA_W  = 32,
  parameter logic [N_GEN*2-1:0]    GEN_ACC = 8'b11_10_01_00,
  parameter logic [N_GEN*DATA_W-1:0] GEN_RST = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_GEN-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [N_GEN-1:0][DATA_W-1:0] rd_vec
);

  for (genvar g = 0; g < N_GEN; g++) begin : g_reg
    localparam acc_e             KIND = acc_e'(GEN_ACC[2*g +: 2]);
    localparam logic [DATA_W-1:0] INIT = GEN_RST[DATA_W*g +: DATA_W];
    logic [DATA_W-1:0] q;

    if (KIND == ACC_RO) begin : g_ro
      assign q = INIT;
    end else if (KIND == ACC_W1C) begin : g_w1c
      always_ff @(posedge clk) begin
        if (rst)            q <= INIT;
        else if (wr_sel[g]) q <= q & ~wr_data;
      end
    end else begin : g_wr
      always_ff @(posedge clk) begin
        if (rst)            q <= INIT;
        else if (wr_sel[g]) q <= wr_data;
      end
    end

    if (KIND == ACC_WO) begin : g_hide
      assign rd_vec[g] = '0;
    end else begin : g_show
      assign rd_vec[g] = q;
    end
  end

endmodule

// File: rtl/mgmt_phy_host.sv
module mgmt_phy_host
  import mgmt_pkg::*;
#(
  parameter int                      ADDR_W  = 4,
  parameter int                      DATA_W  = 32,
  parameter int                      PHY_DW  = 16,
  parameter int                      REG_AW  = 5,
  parameter int                      N_GEN   = 4,
  parameter logic [N_GEN*2-1:0]      GEN_ACC = 8'b11_10_01_00,
  parameter logic [N_GEN*DATA_W-1:0] GEN_RST = {32'hA5A5_0001, 32'h0000_FFFF, 32'h0, 32'h0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_down,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);

  localparam int MAP_END = IDX_GEN0 + N_GEN;

  logic [REG_AW-1:0] sel_phy_q;
  logic [REG_AW-1:0] sel_reg_q;
  logic [DATA_W-1:0] cmd_q;
  logic [PHY_DW-1:0] wdata_q;
  logic [PHY_DW-1:0] result_q;
  logic [DATA_W-1:0] rdata_q;

  logic hit_sel, hit_cmd, hit_wdata;
  logic read_go;
  logic [N_GEN-1:0] gen_sel;
  logic [N_GEN-1:0][DATA_W-1:0] gen_rd;
  logic [PHY_DW-1:0] phy_rd;
  logic [PHY_DW-1:0] phy_ctrl;
  logic              phy_link;
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] rd_next;

  assign hit_sel   = host_wr && host_addr == ADDR_W'(IDX_SEL);
  assign hit_cmd   = host_wr && host_addr == ADDR_W'(IDX_CMD);
  assign hit_wdata = host_wr && host_addr == ADDR_W'(IDX_WDATA);
  assign read_go   = hit_cmd && host_wdata[0] && !cmd_q[0];

  always_comb begin
    for (int i = 0; i < N_GEN; i++)
      gen_sel[i] = host_wr && host_addr == ADDR_W'(IDX_GEN0 + i);
  end

  mgmt_phy_stub #(
    .PHY_DW(PHY_DW),
    .REG_AW(REG_AW)
  ) u_phy (
    .clk      (clk),
    .rst      (rst),
    .link_down(link_down),
    .wr_stb   (hit_wdata),
    .wr_reg   (sel_reg_q),
    .wr_val   (host_wdata[PHY_DW-1:0]),
    .rd_reg   (sel_reg_q),
    .rd_val   (phy_rd),
    .ctrl_out (phy_ctrl),
    .link_out (phy_link)
  );

  mgmt_gen_bank #(
    .N_GEN  (N_GEN),
    .DATA_W (DATA_W),
    .GEN_ACC(GEN_ACC),
    .GEN_RST(GEN_RST)
  ) u_gen (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (gen_sel),
    .wr_data(host_wdata),
    .rd_vec (gen_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_phy_q <= '0;
      sel_reg_q <= '0;
      cmd_q     <= '0;
      wdata_q   <= '0;
      result_q  <= '0;
    end else begin
      if (hit_sel) begin
        sel_phy_q <= host_wdata[SEL_PHY_LSB +: REG_AW];
        sel_reg_q <= host_wdata[SEL_REG_LSB +: REG_AW];
      end
      if (hit_cmd)   cmd_q    <= host_wdata;
      if (read_go)   result_q <= phy_rd;
      if (hit_wdata) wdata_q  <= host_wdata[PHY_DW-1:0];
    end
  end

  always_comb begin
    sel_word = '0;
    sel_word[SEL_PHY_LSB +: REG_AW] = sel_phy_q;
    sel_word[SEL_REG_LSB +: REG_AW] = sel_reg_q;
  end

  always_comb begin
    rd_next = '0;
    if (host_addr == ADDR_W'(IDX_SEL))         rd_next = sel_word;
    else if (host_addr == ADDR_W'(IDX_CMD))    rd_next = cmd_q;
    else if (host_addr == ADDR_W'(IDX_WDATA))  rd_next = DATA_W'(wdata_q);
    else if (host_addr == ADDR_W'(IDX_RESULT)) rd_next = DATA_W'(result_q);
    else begin
      for (int i = 0; i < N_GEN; i++)
        if (host_addr == ADDR_W'(IDX_GEN0 + i)) rd_next = gen_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign host_rdata = rdata_q;

endmodule

// File: rtl/mgmt_phy_host_chk.sv
module mgmt_phy_host_chk
  import mgmt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PHY_DW = 16,
  parameter int REG_AW = 5,
  parameter int N_GEN  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              link_down,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] cmd_q,
  input logic [REG_AW-1:0] sel_reg_q,
  input logic [PHY_DW-1:0] result_q,
  input logic [PHY_DW-1:0] phy_ctrl,
  input logic              phy_link
);

  localparam int MAP_END = IDX_GEN0 + N_GEN;

  logic launch;
  assign launch = host_wr && host_addr == ADDR_W'(IDX_CMD) && host_wdata[0] && !cmd_q[0];

  // R3
  no_spurious_read_chk: assert property (@(posedge clk) disable iff (rst)
    !launch |=> $stable(result_q));

  // R5
  rxok_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && sel_reg_q == REG_AW'(PHY_R_RXOK)) |=> result_q == PHY_DW'(RXOK_PATTERN));

  // R7
  selfclr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    phy_ctrl[15] == 1'b0 && phy_ctrl[8] == 1'b0);

  // R8
  link_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phy_link == !$past(link_down));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(host_addr) >= MAP_END) |=> host_rdata == '0);

endmodule

bind mgmt_phy_host mgmt_phy_host_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .PHY_DW(PHY_DW),
  .REG_AW(REG_AW),
  .N_GEN (N_GEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .link_down (link_down),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_wdata(host_wdata),
  .host_rdata(host_rdata),
  .cmd_q     (cmd_q),
  .sel_reg_q (sel_reg_q),
  .result_q  (result_q),
  .phy_ctrl  (phy_ctrl),
  .phy_link  (phy_link)
);

// File: tb/tb_mgmt_phy_host.sv
`timescale 1ns/1ps
module tb_mgmt_phy_host;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_down = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  mgmt_phy_host dut (
    .clk(clk), .rst(rst), .link_down(link_down),
    .host_addr(addr), .host_wr(wr), .host_wdata(wdata), .host_rdata(rdata)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_sel, m_cmd, m_rd;
  logic [15:0] m_wd, m_res, m_ctrl;
  logic        m_link;
  logic [31:0] m_gen [4];
  string       m_tag = "R1";

  function automatic logic [15:0] phy_value(input logic [4:0] r);
    if (r == 5'd0)  return m_ctrl;
    if (r == 5'd1)  return {13'd0, m_link, 2'b00};
    if (r == 5'd10) return 16'h1800;
    return 16'h0;
  endfunction

  function automatic logic [31:0] host_value(input logic [3:0] a);
    case (a)
      4'd0: return m_sel;
      4'd1: return m_cmd;
      4'd2: return {16'd0, m_wd};
      4'd3: return {16'd0, m_res};
      4'd4: return m_gen[0];
      4'd5: return 32'd0;        // write-only reads 0
      4'd6: return m_gen[2];
      4'd7: return m_gen[3];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R6";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_cmd = 0; m_wd = 0; m_res = 0; m_ctrl = 0; m_rd = 0;
      m_gen[0] = 0; m_gen[1] = 0; m_gen[2] = 32'h0000_FFFF; m_gen[3] = 32'hA5A5_0001;
      m_tag = "R1";
    end else begin
      m_rd  = host_value(addr);
      m_tag = tag_of(addr);
      if (wr) begin
        case (addr)
          4'd0: m_sel = wdata & 32'h0000_1F1F;
          4'd1: begin
            if (wdata[0] && !m_cmd[0]) m_res = phy_value(m_sel[4:0]);
            m_cmd = wdata;
          end
          4'd2: begin
            m_wd = wdata[15:0];
            if (m_sel[4:0] == 5'd0) m_ctrl = wdata[15:0] & 16'h7EFF;
          end
          4'd4: m_gen[0] = wdata;
          4'd5: m_gen[1] = wdata;
          4'd6: m_gen[2] = m_gen[2] & ~wdata;
          default: ;
        endcase
      end
    end
    m_link = !link_down;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s per-clock model: rdata=%h expected=%h", m_tag, rdata, m_rd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic put(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; wr = 1'b0;
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s idx %0d: rdata=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic launch_read();
    put(4'd1, 32'h0);
    put(4'd1, 32'h1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_rd(4'd0, 32'h0, "R1");
    expect_rd(4'd1, 32'h0, "R1");
    expect_rd(4'd3, 32'h0, "R1");
    expect_rd(4'd7, 32'hA5A5_0001, "R1");

    // R2 selector fields
    put(4'd0, 32'hFFFF_FFFF);
    expect_rd(4'd0, 32'h0000_1F1F, "R2");

    // R4 status register, link up (PHY address bits set, no effect: R2)
    put(4'd0, 32'h0000_1F01);
    launch_read();
    expect_rd(4'd3, 32'h0000_0004, "R4");

    // R3 no relaunch while bit stays 1, R8 link change pending
    link_down = 1'b1;
    repeat (3) @(negedge clk);
    put(4'd1, 32'h8000_0003);
    expect_rd(4'd3, 32'h0000_0004, "R3");
    expect_rd(4'd1, 32'h8000_0003, "R3");
    launch_read();
    expect_rd(4'd3, 32'h0000_0000, "R8");
    link_down = 1'b0;

    // R6 / R7 control write with masking
    put(4'd0, 32'h0000_0000);
    put(4'd2, 32'hABCD_FFFF);
    expect_rd(4'd2, 32'h0000_FFFF, "R6");
    launch_read();
    expect_rd(4'd3, 32'h0000_7EFF, "R7");
    put(4'd0, 32'h0000_0001);
    put(4'd2, 32'h0000_0000);
    put(4'd0, 32'h0000_0000);
    launch_read();
    expect_rd(4'd3, 32'h0000_7EFF, "R7");

    // R5 fixed and unmodelled registers
    put(4'd0, 32'h0000_000A);
    launch_read();
    expect_rd(4'd3, 32'h0000_1800, "R5");
    put(4'd0, 32'h0000_0007);
    launch_read();
    expect_rd(4'd3, 32'h0000_0000, "R5");

    // R9 access types
    put(4'd4, 32'h1234_5678);
    expect_rd(4'd4, 32'h1234_5678, "R9");
    put(4'd5, 32'hDEAD_BEEF);
    expect_rd(4'd5, 32'h0000_0000, "R9");
    put(4'd6, 32'h0F0F_00FF);
    expect_rd(4'd6, 32'h0000_FF00, "R9");
    put(4'd7, 32'hFFFF_FFFF);
    expect_rd(4'd7, 32'hA5A5_0001, "R9");

    // R10 unmapped and read-only result
    expect_rd(4'd15, 32'h0, "R10");
    put(4'd3, 32'hFFFF_FFFF);
    expect_rd(4'd3, 32'h0000_0000, "R10");

    // random phase, per-clock model compare
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      addr  = 4'($urandom_range(0, 9));
      wr    = ($urandom_range(0, 2) != 0);
      wdata = $urandom;
      if (addr == 4'd0) begin
        case ($urandom_range(0, 3))
          0: wdata[4:0] = 5'd0;
          1: wdata[4:0] = 5'd1;
          2: wdata[4:0] = 5'd10;
          default: ;
        endcase
      end
      if (addr == 4'd1) wdata[31:1] = '0;
      if ($urandom_range(0, 15) == 0) link_down = ~link_down;
    end
    @(negedge clk);
    wr = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule